// File: doc/BRIEF.md
# Disk Head Positioner Slow-Mode Controller

This block sequences the slow-velocity modes of a disk drive head positioner. It raises a forward slow-mode flag while the heads are loaded onto the platters, and during the final approach of a restore to the initial cylinder. It raises a reverse slow-mode flag while the heads are being unloaded, and during the first, outward part of a restore. It also remembers that a restore was commanded from the host side. While either slow-mode flag is up, it holds an active-low clear request towards the demand-address datapath.

Everything runs on one clock. The load-heads request and the heads-retracted status come from logic in the same clock domain. The transducer index, the quadrature clock, the cylinder address strobe and the restore-to-initial-cylinder line arrive asynchronously. Each of these passes through a two-flop synchronizer, and their edges are found from the synchronized copies. A change on one of these lines therefore acts at the third rising clock edge after it is applied. A change on load-heads acts at the next edge.

Top module: `pmc_positioner_mode`

## Requirements
- R1: After reset, fwdSlow, revSlow and restoreActive are 0 and demandClrN is 1.
- R2: A rising edge of loadHeads, seen while headsRetracted is 1, sets fwdSlow at the first clock edge at which loadHeads is sampled high.
- R3: A rising edge of loadHeads while headsRetracted is 0 leaves fwdSlow unchanged.
- R4: A rising edge of cylStrobe, with restoreInit high at that time, sets restoreActive and revSlow.
- R5: A cylStrobe rising edge with restoreInit low leaves restoreActive, fwdSlow and revSlow unchanged.
- R6: A falling edge of loadHeads sets revSlow.
- R7: While restoreActive is 1, a falling edge of xdcrIndex sets fwdSlow. Whenever fwdSlow is set, revSlow is cleared at the same edge.
- R8: Once xdcrIndex has changed while fwdSlow is 1, fwdSlow is cleared by the next quadClk falling edge that is seen while xdcrIndex is high and either headsRetracted or restoreActive is 1. restoreActive is cleared at the same edge.
- R9: demandClrN is 0 exactly while fwdSlow or revSlow is 1.
- R10: If fwdSlow has a set and a clear condition in the same cycle, it stays set. revSlow clearing takes priority over its own set.
- R11: A change on xdcrIndex, quadClk, cylStrobe or restoreInit takes effect at the third rising clock edge after it is applied. It has no effect at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadHeads | input | 1 | Load-heads request (synchronous level) |
| headsRetracted | input | 1 | Heads parked off the media (synchronous level) |
| xdcrIndex | input | 1 | Position transducer index (asynchronous) |
| quadClk | input | 1 | Position quadrature clock (asynchronous) |
| cylStrobe | input | 1 | Cylinder address strobe from the host side (asynchronous) |
| restoreInit | input | 1 | Restore-to-initial-cylinder line (asynchronous) |
| fwdSlow | output | 1 | Forward slow velocity mode |
| revSlow | output | 1 | Reverse slow velocity mode |
| restoreActive | output | 1 | A restore is in progress |
| demandClrN | output | 1 | Active-low demand-address clear |

## Verification
The hardest case to reach from the ports is a forward slow-mode set and clear landing on the same clock edge. To get there, the clear must first be armed by an index change. Then a synchronized quadrature falling edge, three edges after the input moves, must line up with a synchronous load-heads rising edge, which acts after one edge. The directed part of the stimulus arms the clear, drops quadClk, and raises loadHeads two cycles later so that both events meet. Long random runs with rare input toggles then reach the restore sequences, and the overlaps between them, many times.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  // Single-cycle strobes handed from the event datapath to the mode control
  typedef struct packed {
    logic loadRise;
    logic loadFall;
    logic restoreCmd;
    logic indexFall;
    logic indexChange;
    logic indexHigh;
    logic quadFall;
  } pmcEvents_t;

  localparam int ASYNC_LINES = 4;
  localparam int LINE_INDEX  = 0;
  localparam int LINE_QUAD   = 1;
  localparam int LINE_STROBE = 2;
  localparam int LINE_RINIT  = 3;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pmc_event_dp.sv
module pmc_event_dp
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadHeads,
  input  logic       xdcrIndex,
  input  logic       quadClk,
  input  logic       cylStrobe,
  input  logic       restoreInit,
  output pmcEvents_t ev
);

  logic [ASYNC_LINES-1:0] rawLines;
  logic [ASYNC_LINES-1:0] syncLines;
  logic                   indexPrev;
  logic                   quadPrev;
  logic                   strobePrev;
  logic                   loadPrev;

  always_comb begin
    rawLines              = '0;
    rawLines[LINE_INDEX]  = xdcrIndex;
    rawLines[LINE_QUAD]   = quadClk;
    rawLines[LINE_STROBE] = cylStrobe;
    rawLines[LINE_RINIT]  = restoreInit;
  end

  pmc_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (ASYNC_LINES)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawLines),
    .dout(syncLines)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexPrev  <= 1'b0;
      quadPrev   <= 1'b0;
      strobePrev <= 1'b0;
      loadPrev   <= 1'b0;
    end else begin
      indexPrev  <= syncLines[LINE_INDEX];
      quadPrev   <= syncLines[LINE_QUAD];
      strobePrev <= syncLines[LINE_STROBE];
      loadPrev   <= loadHeads;
    end
  end

  always_comb begin
    ev.loadRise    = loadHeads & ~loadPrev;
    ev.loadFall    = ~loadHeads & loadPrev;
    ev.restoreCmd  = syncLines[LINE_STROBE] & ~strobePrev & syncLines[LINE_RINIT];
    ev.indexFall   = ~syncLines[LINE_INDEX] & indexPrev;
    ev.indexChange = syncLines[LINE_INDEX] ^ indexPrev;
    ev.indexHigh   = syncLines[LINE_INDEX];
    ev.quadFall    = ~syncLines[LINE_QUAD] & quadPrev;
  end

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pmcEvents_t ev,
  input  logic       headsRetracted,
  output logic       fwdSlow,
  output logic       revSlow,
  output logic       restoreActive
);

  logic clrArmed;
  logic fwdSet;
  logic fwdClr;
  logic fwdNext;
  logic revNext;
  logic restNext;
  logic armNext;

  always_comb begin
    fwdSet = (ev.loadRise & headsRetracted) | (restoreActive & ev.indexFall);
    fwdClr = fwdSlow & clrArmed & ev.quadFall & ev.indexHigh
             & (headsRetracted | restoreActive);

    // forward: set beats clear
    if (fwdSet)      fwdNext = 1'b1;
    else if (fwdClr) fwdNext = 1'b0;
    else             fwdNext = fwdSlow;

    // reverse: cleared by a forward set, ahead of its own set
    if (fwdSet)                          revNext = 1'b0;
    else if (ev.restoreCmd | ev.loadFall) revNext = 1'b1;
    else                                 revNext = revSlow;

    // restore ends with the forward clear
    if (ev.restoreCmd)           restNext = 1'b1;
    else if (fwdClr && !fwdSet)  restNext = 1'b0;
    else                         restNext = restoreActive;

    // clear is armed by an index change seen while forward is up
    if (fwdSet || fwdClr)                armNext = 1'b0;
    else if (fwdSlow && ev.indexChange)  armNext = 1'b1;
    else                                 armNext = clrArmed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdSlow       <= 1'b0;
      revSlow       <= 1'b0;
      restoreActive <= 1'b0;
      clrArmed      <= 1'b0;
    end else begin
      fwdSlow       <= fwdNext;
      revSlow       <= revNext;
      restoreActive <= restNext;
      clrArmed      <= armNext;
    end
  end

endmodule

// File: rtl/pmc_positioner_mode.sv
module pmc_positioner_mode
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic loadHeads,
  input  logic headsRetracted,
  input  logic xdcrIndex,
  input  logic quadClk,
  input  logic cylStrobe,
  input  logic restoreInit,
  output logic fwdSlow,
  output logic revSlow,
  output logic restoreActive,
  output logic demandClrN
);

  pmcEvents_t ev;

  pmc_event_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uEventDp (
    .clk        (clk),
    .rstN       (rstN),
    .loadHeads  (loadHeads),
    .xdcrIndex  (xdcrIndex),
    .quadClk    (quadClk),
    .cylStrobe  (cylStrobe),
    .restoreInit(restoreInit),
    .ev         (ev)
  );

  pmc_mode_ctrl uModeCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .ev            (ev),
    .headsRetracted(headsRetracted),
    .fwdSlow       (fwdSlow),
    .revSlow       (revSlow),
    .restoreActive (restoreActive)
  );

  assign demandClrN = ~(fwdSlow | revSlow);

endmodule

// File: rtl/pmc_positioner_mode_chk.sv
module pmc_positioner_mode_chk (
  input logic clk,
  input logic rstN,
  input logic loadRise,
  input logic headsRetracted,
  input logic fwdSlow,
  input logic revSlow,
  input logic restoreActive,
  input logic demandClrN
);

  a_r2_load_sets_fwd: assert property (@(posedge clk) disable iff (!rstN)
    (loadRise && headsRetracted) |=> fwdSlow);

  a_r7_fwd_clears_rev: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdSlow) |-> !revSlow);

  a_r8_restore_ends_with_fwd: assert property (@(posedge clk) disable iff (!rstN)
    $fell(restoreActive) |-> $fell(fwdSlow));

  a_r4_restore_has_slow: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restoreActive) |-> (revSlow || fwdSlow));

  a_r9_clear_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(demandClrN) |-> ($fell(fwdSlow) || $fell(revSlow)));

endmodule

bind pmc_positioner_mode pmc_positioner_mode_chk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .loadRise      (ev.loadRise),
  .headsRetracted(headsRetracted),
  .fwdSlow       (fwdSlow),
  .revSlow       (revSlow),
  .restoreActive (restoreActive),
  .demandClrN    (demandClrN)
);

// File: tb/sim_pmc_positioner_mode.sv
`timescale 1ns/1ps
module sim_pmc_positioner_mode;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadHeads = 1'b0, headsRetracted = 1'b0, xdcrIndex = 1'b0;
  logic quadClk = 1'b0, cylStrobe = 1'b0, restoreInit = 1'b0;
  logic fwdSlow, revSlow, restoreActive, demandClrN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  logic iS1, iS2, iP, qS1, qS2, qP, sS1, sS2, sP, rS1, rS2, lP;
  logic mFwd, mRev, mRest, mArm;

  always #10 clk = ~clk;  // 50 MHz

  pmc_positioner_mode u0 (
    .clk(clk), .rstN(rstN), .loadHeads(loadHeads), .headsRetracted(headsRetracted),
    .xdcrIndex(xdcrIndex), .quadClk(quadClk), .cylStrobe(cylStrobe),
    .restoreInit(restoreInit), .fwdSlow(fwdSlow), .revSlow(revSlow),
    .restoreActive(restoreActive), .demandClrN(demandClrN)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    {iS1, iS2, iP, qS1, qS2, qP, sS1, sS2, sP, rS1, rS2, lP} = '0;
    {mFwd, mRev, mRest, mArm} = '0;
  endfunction

  function automatic void modelEdge();
    logic lRise, lFall, cmd, iFall, iChg, qFall, set, clr;
    lRise = loadHeads & ~lP;
    lFall = ~loadHeads & lP;
    cmd   = sS2 & ~sP & rS2;          // R4
    iFall = ~iS2 & iP;
    iChg  = iS2 ^ iP;
    qFall = ~qS2 & qP;
    set   = (lRise & headsRetracted) | (mRest & iFall);          // R2 R7
    clr   = mFwd & mArm & qFall & iS2 & (headsRetracted | mRest); // R8
    if (set || clr) mArm = 1'b0;
    else if (mFwd && iChg) mArm = 1'b1;
    if (cmd) mRest = 1'b1;
    else if (clr && !set) mRest = 1'b0;
    if (set) mRev = 1'b0;                                         // R10
    else if (cmd || lFall) mRev = 1'b1;                           // R6
    mFwd = set ? 1'b1 : (clr ? 1'b0 : mFwd);                      // R10
    iP = iS2; iS2 = iS1; iS1 = xdcrIndex;                         // R11
    qP = qS2; qS2 = qS1; qS1 = quadClk;
    sP = sS2; sS2 = sS1; sS1 = cylStrobe;
    rS2 = rS1; rS1 = restoreInit;
    lP = loadHeads;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    modelEdge();
    @(negedge clk);
    check(fwdSlow, mFwd, "R2", "fwdSlow vs model");
    check(revSlow, mRev, "R6", "revSlow vs model");
    check(restoreActive, mRest, "R4", "restoreActive vs model");
    check(demandClrN, ~(mFwd | mRev), "R9", "demandClrN vs model");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(fwdSlow, 1'b0, "R1", "fwdSlow after reset");
    check(revSlow, 1'b0, "R1", "revSlow after reset");
    check(restoreActive, 1'b0, "R1", "restoreActive after reset");
    check(demandClrN, 1'b1, "R1", "demandClrN after reset");

    // R3 load request while heads not retracted
    loadHeads = 1'b1; step();
    check(fwdSlow, 1'b0, "R3", "fwd with heads not retracted");
    // R6 unload
    loadHeads = 1'b0; step();
    check(revSlow, 1'b1, "R6", "rev after load drop");
    check(demandClrN, 1'b0, "R9", "clear asserted by rev");
    // R2 load with heads retracted, R7 rev cleared
    headsRetracted = 1'b1; loadHeads = 1'b1; step();
    check(fwdSlow, 1'b1, "R2", "fwd after load");
    check(revSlow, 1'b0, "R7", "rev cleared by fwd set");
    // R8 index change arms, quad fall clears; R11 timing
    xdcrIndex = 1'b1; run(3);
    quadClk = 1'b1; run(3);
    quadClk = 1'b0; run(2);
    check(fwdSlow, 1'b1, "R11", "fwd still set at second edge");
    step();
    check(fwdSlow, 1'b0, "R8", "fwd cleared by quad fall");
    check(demandClrN, 1'b1, "R9", "clear released");
    // R5 strobe without restore line
    cylStrobe = 1'b1; run(4); cylStrobe = 1'b0; run(3);
    check(restoreActive, 1'b0, "R5", "restore after plain strobe");
    check(revSlow, 1'b0, "R5", "rev after plain strobe");
    check(fwdSlow, 1'b0, "R5", "fwd after plain strobe");
    // R4 restore command, R11 latency
    headsRetracted = 1'b0;
    restoreInit = 1'b1; cylStrobe = 1'b1; run(2);
    check(restoreActive, 1'b0, "R11", "restore not yet at second edge");
    step();
    check(restoreActive, 1'b1, "R4", "restore after command");
    check(revSlow, 1'b1, "R4", "rev after command");
    cylStrobe = 1'b0; restoreInit = 1'b0; run(3);
    // R7 index fall during restore
    xdcrIndex = 1'b0; run(3);
    check(fwdSlow, 1'b1, "R7", "fwd on index fall in restore");
    check(revSlow, 1'b0, "R7", "rev cleared in restore");
    // R8 end of restore
    xdcrIndex = 1'b1; run(3);
    quadClk = 1'b1; run(3);
    quadClk = 1'b0; run(3);
    check(fwdSlow, 1'b0, "R8", "fwd cleared at restore end");
    check(restoreActive, 1'b0, "R8", "restore cleared at end");
    // R10 set and clear of fwd on the same edge
    headsRetracted = 1'b1; loadHeads = 1'b0; step();
    loadHeads = 1'b1; step();
    check(fwdSlow, 1'b1, "R2", "fwd set for R10 setup");
    xdcrIndex = 1'b0; run(3); xdcrIndex = 1'b1; run(3);
    quadClk = 1'b1; run(3);
    loadHeads = 1'b0; step();
    check(revSlow, 1'b1, "R6", "rev set while fwd held");
    quadClk = 1'b0; step(); step();
    loadHeads = 1'b1; step();
    check(fwdSlow, 1'b1, "R10", "set wins over clear");
    check(revSlow, 1'b0, "R10", "rev clear wins");

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(15) == 0) loadHeads      = ~loadHeads;
      if ($urandom_range(23) == 0) headsRetracted = ~headsRetracted;
      if ($urandom_range(7)  == 0) xdcrIndex      = ~xdcrIndex;
      if ($urandom_range(3)  == 0) quadClk        = ~quadClk;
      if ($urandom_range(19) == 0) cylStrobe      = ~cylStrobe;
      if ($urandom_range(9)  == 0) restoreInit    = ~restoreInit;
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule